// File: doc/BRIEF.md
# Printer Port Register Model

This block presents the host side of a classic byte-wide printer port as three registers on a simple synchronous bus. The host writes a byte into the output data register. It then toggles the strobe bit of the control register to hand that byte to the printer. The byte appears on an output stream together with a one-cycle valid pulse.

A status register models the printer's answer. A strobe release drops the busy bit. Later status reads step through an acknowledge and busy sequence, so that a driver polling the port sees a plausible handshake. A strobe assertion with interrupts enabled raises a pending flag, and that flag drives a level interrupt line until the next status read.

A direction bit in the control register chooses what a data read returns. When it is set, the read returns the external input byte. When it is clear, the read returns the last byte written. Reads are registered. Only the low three address bits are decoded.

Top module: `pport_regs`

## Requirements
- R1: After reset, reading offset 0 returns 0xFF, offset 1 returns 0xD9, offset 2 returns 0xCC, and irq_o is 0.
- R2: Only address bits [2:0] are decoded. Offset 0 is data, 1 is status and 2 is control. A read of offsets 3 to 7 returns 0xFF, and upper address bits are ignored (address 0x0A reads control).
- R3: Every control write is stored with bits 7 and 6 forced to 1.
- R4: A control write with bit 2 (init) at 0 sets status to 0xD8.
- R5: A control write with init=1, select (bit 3)=1 and strobe (bit 0)=1 clears status bit 7 (busy). If the stored strobe was 0 before the write, out_valid_o is high for that cycle only, and out_byte_o carries the data register.
- R6: A control write with init=1, select=1 and strobe=0 sets the interrupt-pending flag only when the previously stored control has bit 4 (interrupt enable) set.
- R7: A status read returns the status value from before the read, and it clears the interrupt-pending flag.
- R8: On a status read with busy=0 and a stored strobe of 0, the read clears status bit 6 (ack) if ack was 1. If ack was 0, it sets both ack and busy.
- R9: A data read returns in_byte_i when control bit 5 (direction) is 1, and returns the written data byte otherwise.
- R10: bus_rdata_o changes only in the clock after a cycle with bus_re_i high, and it holds its value otherwise.
- R11: irq_o equals the interrupt-pending flag. It is updated in the clock after a data write, a control write or a status read.
- R12: A control write with init=1 and select=0 stores the control value, leaves the status unchanged and emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | ADDR_W | Register address; bits [2:0] decoded |
| bus_we_i | input | 1 | Write enable |
| bus_re_i | input | 1 | Read enable |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| out_byte_o | output | 8 | Byte handed to the printer |
| out_valid_o | output | 1 | One-cycle pulse marking out_byte_o |
| in_byte_i | input | 8 | External input byte for data reads |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that the host never asserts write enable and read enable in the same clock. The checker flags any cycle where it does. All bench stimulus issues exactly one operation or an idle cycle per clock, and it changes the bus only on the falling edge. The interrupt and read-data properties therefore relate each output change to the single operation sampled at the previous rising edge.

// File: rtl/pport_pkg.sv
package pport_pkg;
    localparam int REG_W = 8;
    typedef logic [REG_W-1:0] byte_t;

    localparam logic [2:0] OFF_DATA = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd1;
    localparam logic [2:0] OFF_CTRL = 3'd2;
    localparam int OFF_W = 3;

    localparam int ST_BUSY = 7;
    localparam int ST_ACK  = 6;

    localparam int CT_STB   = 0;
    localparam int CT_INIT  = 2;
    localparam int CT_SEL   = 3;
    localparam int CT_IRQEN = 4;
    localparam int CT_DIR   = 5;

    localparam byte_t STAT_RST   = 8'hD9;
    localparam byte_t STAT_INIT  = 8'hD8;
    localparam byte_t CTRL_RST   = 8'hCC;
    localparam byte_t CTRL_FORCE = 8'hC0;
    localparam byte_t DATA_RST   = 8'hFF;
    localparam byte_t IDLE_READ  = 8'hFF;

    typedef struct packed {
        byte_t dataw;
        byte_t stat;
        byte_t ctrl;
        byte_t rdata;
        logic  pend;
        logic  irq;
    } regs_t;
endpackage

// File: rtl/pport_ctl_decode.sv
module pport_ctl_decode
    import pport_pkg::*;
(
    input  byte_t wr_val_i,
    input  logic  prev_strobe_i,
    input  logic  prev_irqen_i,
    input  byte_t stat_q_i,
    output byte_t ctrl_o,
    output byte_t stat_o,
    output logic  pend_set_o,
    output logic  emit_o
);
    byte_t val;

    always_comb begin
        val        = wr_val_i | CTRL_FORCE;
        ctrl_o     = val;
        stat_o     = stat_q_i;
        pend_set_o = 1'b0;
        emit_o     = 1'b0;
        if (!val[CT_INIT]) begin
            stat_o = STAT_INIT;
        end else if (val[CT_SEL]) begin
            if (val[CT_STB]) begin
                stat_o[ST_BUSY] = 1'b0;
                emit_o          = !prev_strobe_i;
            end else begin
                pend_set_o = prev_irqen_i;
            end
        end
    end
endmodule

// File: rtl/pport_sts_seq.sv
module pport_sts_seq
    import pport_pkg::*;
(
    input  byte_t stat_q_i,
    input  logic  strobe_q_i,
    output byte_t stat_o
);
    always_comb begin
        stat_o = stat_q_i;
        if (!stat_q_i[ST_BUSY] && !strobe_q_i) begin
            if (stat_q_i[ST_ACK]) begin
                stat_o[ST_ACK] = 1'b0;
            end else begin
                stat_o[ST_ACK]  = 1'b1;
                stat_o[ST_BUSY] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pport_rd_mux.sv
module pport_rd_mux
    import pport_pkg::*;
(
    input  logic [OFF_W-1:0] off_i,
    input  byte_t            dataw_i,
    input  byte_t            in_byte_i,
    input  byte_t            stat_i,
    input  byte_t            ctrl_i,
    output byte_t            rdata_o
);
    always_comb begin
        unique case (off_i)
            OFF_DATA: rdata_o = ctrl_i[CT_DIR] ? in_byte_i : dataw_i;
            OFF_STAT: rdata_o = stat_i;
            OFF_CTRL: rdata_o = ctrl_i;
            default:  rdata_o = IDLE_READ;
        endcase
    end
endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic              bus_re_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic [7:0]        out_byte_o,
    output logic              out_valid_o,
    input  logic [7:0]        in_byte_i,
    output logic              irq_o
);
    regs_t q, d;
    logic [OFF_W-1:0] off;
    byte_t dec_ctrl, dec_stat, seq_stat, mux_val;
    logic  dec_pend_set, dec_emit;

    assign off = bus_addr_i[OFF_W-1:0];

    generate
        if (ADDR_W > OFF_W) begin : g_hi_addr
            logic unused_hi_addr;
            assign unused_hi_addr = ^bus_addr_i[ADDR_W-1:OFF_W];
        end
    endgenerate

    pport_ctl_decode u_dec (
        .wr_val_i      (bus_wdata_i),
        .prev_strobe_i (q.ctrl[CT_STB]),
        .prev_irqen_i  (q.ctrl[CT_IRQEN]),
        .stat_q_i      (q.stat),
        .ctrl_o        (dec_ctrl),
        .stat_o        (dec_stat),
        .pend_set_o    (dec_pend_set),
        .emit_o        (dec_emit)
    );

    pport_sts_seq u_seq (
        .stat_q_i   (q.stat),
        .strobe_q_i (q.ctrl[CT_STB]),
        .stat_o     (seq_stat)
    );

    pport_rd_mux u_mux (
        .off_i     (off),
        .dataw_i   (q.dataw),
        .in_byte_i (in_byte_i),
        .stat_i    (q.stat),
        .ctrl_i    (q.ctrl),
        .rdata_o   (mux_val)
    );

    always_comb begin
        d           = q;
        out_valid_o = 1'b0;
        if (bus_we_i) begin
            if (off == OFF_DATA) begin
                d.dataw = bus_wdata_i;
                d.irq   = d.pend;
            end else if (off == OFF_CTRL) begin
                d.ctrl      = dec_ctrl;
                d.stat      = dec_stat;
                d.pend      = q.pend | dec_pend_set;
                d.irq       = d.pend;
                out_valid_o = dec_emit;
            end
        end
        if (bus_re_i) begin
            d.rdata = mux_val;
            if (off == OFF_STAT) begin
                d.pend = 1'b0;
                d.stat = seq_stat;
                d.irq  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.dataw <= DATA_RST;
            q.stat  <= STAT_RST;
            q.ctrl  <= CTRL_RST;
            q.rdata <= IDLE_READ;
            q.pend  <= 1'b0;
            q.irq   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata_o = q.rdata;
    assign out_byte_o  = q.dataw;
    assign irq_o       = q.irq;
endmodule

// File: rtl/pport_regs_chk.sv
module pport_regs_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_we_i,
    input logic              bus_re_i,
    input logic [7:0]        bus_wdata_i,
    input logic [7:0]        bus_rdata_o,
    input logic              out_valid_o,
    input logic              irq_o
);
    logic wr_ctl, rd_sts, ctl_assert_stb;
    assign wr_ctl = bus_we_i && (bus_addr_i[2:0] == 3'd2);
    assign rd_sts = bus_re_i && (bus_addr_i[2:0] == 3'd1);
    assign ctl_assert_stb = wr_ctl && bus_wdata_i[2] && bus_wdata_i[3] && !bus_wdata_i[0];

    assert_single_op_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_we_i && bus_re_i));

    assert_emit_needs_ctl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> (wr_ctl && bus_wdata_i[0]));

    assert_emit_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |=> !out_valid_o);

    assert_irq_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(ctl_assert_stb));

    assert_irq_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_o) |-> $past(rd_sts));

    assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(bus_re_i) |-> $stable(bus_rdata_o));
endmodule

bind pport_regs pport_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_re_i    (bus_re_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .out_valid_o (out_valid_o),
    .irq_o       (irq_o)
);

// File: tb/pport_regs_bench.sv
module pport_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       we = 1'b0, re = 1'b0;
    logic [7:0] wdata = '0, in_byte = '0;
    logic [7:0] rdata, obyte;
    logic       ovalid, irq;

    int tests = 0, fails = 0;
    bit done = 0;

    int m_dataw, m_stat, m_ctrl, m_rdata;
    bit m_pend, m_irq;

    always #5 clk = ~clk;

    pport_regs #(.ADDR_W(8)) u_pport_regs (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
        .bus_re_i(re), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .out_byte_o(obyte), .out_valid_o(ovalid), .in_byte_i(in_byte), .irq_o(irq)
    );

    task automatic chk(int act, int exp, string req, string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_edge(bit w, bit r, int a, int v);
        int off = a & 7;
        int cv;
        if (w) begin
            if (off == 0) begin
                m_dataw = v; m_irq = m_pend;
            end else if (off == 2) begin
                cv = v | 8'hC0;
                if ((cv & 4) == 0) m_stat = 8'hD8;
                else if ((cv & 8) != 0) begin
                    if ((cv & 1) != 0) m_stat = m_stat & 8'h7F;
                    else if ((m_ctrl & 16) != 0) m_pend = 1;
                end
                m_ctrl = cv; m_irq = m_pend;
            end
        end
        if (r) begin
            case (off)
                0: m_rdata = ((m_ctrl & 32) != 0) ? int'(in_byte) : m_dataw;
                1: begin
                    m_rdata = m_stat; m_pend = 0; m_irq = 0;
                    if ((m_stat & 8'h80) == 0 && (m_ctrl & 1) == 0) begin
                        if ((m_stat & 8'h40) != 0) m_stat = m_stat & 8'hBF;
                        else m_stat = m_stat | 8'hC0;
                    end
                end
                2: m_rdata = m_ctrl;
                default: m_rdata = 8'hFF;
            endcase
        end
    endtask

    // one bus cycle; entered and left at a falling edge
    task automatic op(bit w, bit r, int a, int v, string req);
        int cv = v | 8'hC0;
        bit exp_v;
        addr = a[7:0]; we = w; re = r; wdata = v[7:0];
        #1;
        exp_v = w && ((a & 7) == 2) && ((cv & 12) == 12) && ((cv & 1) != 0) && ((m_ctrl & 1) == 0);
        chk(int'(ovalid), int'(exp_v), req, "out_valid");
        if (exp_v) chk(int'(obyte), m_dataw, req, "out_byte");
        @(posedge clk);
        model_edge(w, r, a, v);
        @(negedge clk);
        we = 0; re = 0;
        chk(int'(rdata), m_rdata, req, "rdata");
        chk(int'(irq), int'(m_irq), req, "irq");
    endtask

    task automatic rd(int a, int exp, string req);
        op(0, 1, a, 0, req);
        chk(int'(rdata), exp, req, "read value");
    endtask

    task automatic wr(int a, int v, string req);
        op(1, 0, a, v, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed = 32'h1234_5678;
        m_dataw = 8'hFF; m_stat = 8'hD9; m_ctrl = 8'hCC; m_rdata = 8'hFF;
        m_pend = 0; m_irq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(int'(irq), 0, "R1", "irq after reset");
        rd(0, 8'hFF, "R1");
        rd(1, 8'hD9, "R1");
        rd(2, 8'hCC, "R1");
        rd(3, 8'hFF, "R2");
        rd(7, 8'hFF, "R2");
        rd(8'h0A, 8'hCC, "R2");
        wr(2, 8'h0C, "R3");
        rd(2, 8'hCC, "R3");
        wr(0, 8'h41, "R9");
        rd(0, 8'h41, "R9");
        wr(2, 8'h0D, "R5");
        rd(1, 8'h59, "R5");
        rd(1, 8'h59, "R8");
        wr(2, 8'h0C, "R6");
        chk(int'(irq), 0, "R6", "no irq without enable");
        rd(1, 8'h59, "R8");
        rd(1, 8'h19, "R8");
        rd(1, 8'hD9, "R8");
        rd(1, 8'hD9, "R8");
        wr(2, 8'h0D, "R5");
        wr(2, 8'h0D, "R5");
        wr(2, 8'h1C, "R6");
        chk(int'(irq), 0, "R6", "enable only in new value");
        wr(2, 8'h1D, "R5");
        wr(2, 8'h1C, "R6");
        chk(int'(irq), 1, "R6", "irq raised");
        wr(0, 8'h55, "R11");
        chk(int'(irq), 1, "R11", "irq held over data write");
        op(0, 0, 0, 0, "R10");
        rd(1, 8'h59, "R7");
        chk(int'(irq), 0, "R7", "irq cleared by status read");
        wr(2, 8'h05, "R12");
        rd(2, 8'hC5, "R12");
        rd(1, 8'h19, "R12");
        wr(2, 8'h08, "R4");
        rd(1, 8'hD8, "R4");
        wr(2, 8'h2C, "R9");
        in_byte = 8'h3C;
        rd(0, 8'h3C, "R9");
        in_byte = 8'hA5;
        rd(0, 8'hA5, "R9");
        in_byte = 8'h00;
        op(0, 0, 0, 0, "R10");
        chk(int'(rdata), 8'hA5, "R10", "read data held");
        for (int i = 0; i < 400; i++) begin
            int kind;
            seed = seed * 1103515245 + 12345;
            kind = (seed >>> 16) & 3;
            in_byte = seed[7:0];
            if (kind == 0) op(0, 0, (seed >>> 8) & 7, 0, "R10");
            else if (kind == 1) op(0, 1, (seed >>> 8) & 7, 0, "R8");
            else op(1, 0, ((seed >>> 8) & 1) ? 2 : ((seed >>> 9) & 3), (seed >>> 20) & 8'hFF, "R5");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule